// File: doc/BRIEF.md
# IO Delay Recalibration Sequencer

This block runs the full recalibration of the pad delay lines after the core supply has been moved to a new level. One pulse on `start_i` starts a fixed series of steps. The sequencer opens the delay configuration registers with a key write, programs the reference clock period, and runs a calibration. It then isolates the pads and reloads the delay lines with the new values. With the pads still isolated, it asks for the pad multiplexing to be applied, then releases the isolation and closes the configuration registers with a second key write.

The configuration register file has a plain single-cycle write strobe. Each of the other steps is a request/done handshake. The sequencer raises the request and holds it until it samples done high on a clock edge. A done seen while the request is low has no effect. The responder may assert done in the same cycle the request appears. The waits for calibration, isolation, reload, pad multiplexing and release are each bounded by a cycle limit. When a wait fails, the sequencer skips the remaining steps, still performs the closing key write, and reports a single-bit error code. The error code is shown only once the whole sequence has ended, because no IO can carry status while the pads are isolated.

Top module: `iorecal_seq`

## Requirements
- R1: A `start_i` pulse is accepted only while `busy_o` is low. The opening key write (`cfg_wr_addr_o`=0, data `UNLOCK_KEY`, default 16'hAAAA) appears in the cycle after the pulse. A pulse seen while `busy_o` is high is ignored and the running sequence is unchanged.
- R2: A sequence that fails nowhere performs its steps in exactly this order: opening key write, period write, calibration, isolate, reload, pad multiplexing, release, closing key write, done.
- R3: There are three configuration writes. The period write uses `cfg_wr_addr_o`=1 with data `REF_PERIOD` (default 16'h02EF). The two key writes use `cfg_wr_addr_o`=0: 16'hAAAA opens and 16'hAAAB (`LOCK_KEY`) closes. At most one write or request is active in any cycle.
- R4: A request stays high from its first cycle until the cycle in which its done input is high. It drops in the following cycle.
- R5: A wait whose done is high in its `TIMEOUT_CYC`-th cycle still succeeds. A wait that has seen no done after `TIMEOUT_CYC` cycles fails, and its request is high for exactly `TIMEOUT_CYC` cycles.
- R6: After a failed wait, no later step is requested. The closing key write follows at once, and then done.
- R7: `err_code_o` encodings: 4'h0 success, 4'h1 calibration timeout, 4'h4 isolate timeout, 4'h8 reload timeout, 4'h2 for a pad-multiplexing or release timeout (IOs left isolated).
- R8: `err_code_o` reads 0 throughout every cycle with `busy_o` high. It carries the result in the done cycle and holds it until the next accepted start.
- R9: `done_o` is a one-cycle pulse in the cycle after the closing key write. `busy_o` is low from that cycle on.
- R10: `mux_req_o` is raised only while the pads are isolated, that is, after a completed isolate handshake and before a completed release.
- R11: `iso_on_o` reads 1 during the isolate request and 0 during the release request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start_i | input | 1 | start pulse |
| busy_o | output | 1 | sequence in progress |
| done_o | output | 1 | one-cycle end-of-sequence pulse |
| err_code_o | output | 4 | result code, shown after the sequence ends |
| cfg_wr_en_o | output | 1 | configuration write strobe |
| cfg_wr_addr_o | output | 2 | 0 key register, 1 period register |
| cfg_wr_data_o | output | KEY_W | configuration write data |
| cal_req_o | output | 1 | calibration request |
| cal_done_i | input | 1 | calibration finished |
| iso_req_o | output | 1 | isolation change request |
| iso_on_o | output | 1 | 1 isolate, 0 release |
| iso_done_i | input | 1 | isolation change finished |
| reload_req_o | output | 1 | delay-line reload request |
| reload_done_i | input | 1 | reload finished |
| mux_req_o | output | 1 | pad multiplexing request |
| mux_ack_i | input | 1 | pad multiplexing applied |

## Verification
Responders that answer at once check the step order and the write encodings with little waiting. Responders that answer in the final allowed cycle separate a correct limit from one that is off by one in the early direction. A separate run with the calibration answer one cycle late catches an error in the other direction. Each wait is starved in turn so that every error code is tied to the one step that owns it, and the last steps reached before the closing write can be checked. A start pulse sent in mid-run, and a failed run followed by a clean one, show whether a busy start is ignored and whether the error code is held and then cleared.

// File: rtl/iorecal_pkg.sv
package iorecal_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_UNLOCK, ST_PERIOD, ST_CAL, ST_ISO,
    ST_RELOAD, ST_MUX, ST_DEISO, ST_LOCK, ST_FIN
  } rc_state_e;

  localparam logic [3:0] ERR_NONE   = 4'h0;
  localparam logic [3:0] ERR_CAL    = 4'h1;
  localparam logic [3:0] ERR_DEISO  = 4'h2;
  localparam logic [3:0] ERR_ISO    = 4'h4;
  localparam logic [3:0] ERR_RELOAD = 4'h8;

  localparam logic [1:0] CFG_ADDR_KEY    = 2'd0;
  localparam logic [1:0] CFG_ADDR_PERIOD = 2'd1;

  // successor of a step when it completes normally
  function automatic rc_state_e step_after(rc_state_e s);
    case (s)
      ST_UNLOCK: return ST_PERIOD;
      ST_PERIOD: return ST_CAL;
      ST_CAL:    return ST_ISO;
      ST_ISO:    return ST_RELOAD;
      ST_RELOAD: return ST_MUX;
      ST_MUX:    return ST_DEISO;
      ST_DEISO:  return ST_LOCK;
      ST_LOCK:   return ST_FIN;
      default:   return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/iorecal_wait_timer.sv
module iorecal_wait_timer #(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic active_i,
  input  logic hit_i,
  output logic expired_o
);
  localparam int CW = (TIMEOUT_CYC < 2) ? 1 : $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (clr_i || !active_i) cnt_q <= '0;
    else if (cnt_q != LAST)      cnt_q <= cnt_q + 1'b1;
  end

  // a done arriving in the last allowed cycle wins over the limit
  assign expired_o = active_i && !hit_i && (cnt_q == LAST);
endmodule

// File: rtl/iorecal_step_port.sv
module iorecal_step_port
  import iorecal_pkg::*;
#(
  parameter int          KEY_W      = 16,
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hAAAA,
  parameter logic [KEY_W-1:0] LOCK_KEY   = 16'hAAAB,
  parameter logic [KEY_W-1:0] REF_PERIOD = 16'h02EF
) (
  input  rc_state_e        st_i,
  input  logic             cal_done_i,
  input  logic             iso_done_i,
  input  logic             reload_done_i,
  input  logic             mux_ack_i,
  output logic             cal_req_o,
  output logic             iso_req_o,
  output logic             iso_on_o,
  output logic             reload_req_o,
  output logic             mux_req_o,
  output logic             cfg_wr_en_o,
  output logic [1:0]       cfg_wr_addr_o,
  output logic [KEY_W-1:0] cfg_wr_data_o,
  output logic             waiting_o,
  output logic             step_hit_o,
  output logic [3:0]       fail_code_o
);
  always_comb begin
    cal_req_o     = 1'b0;
    iso_req_o     = 1'b0;
    iso_on_o      = 1'b0;
    reload_req_o  = 1'b0;
    mux_req_o     = 1'b0;
    cfg_wr_en_o   = 1'b0;
    cfg_wr_addr_o = CFG_ADDR_KEY;
    cfg_wr_data_o = '0;
    waiting_o     = 1'b0;
    step_hit_o    = 1'b0;
    fail_code_o   = ERR_NONE;
    case (st_i)
      ST_UNLOCK: begin
        cfg_wr_en_o   = 1'b1;
        cfg_wr_data_o = UNLOCK_KEY;
      end
      ST_PERIOD: begin
        cfg_wr_en_o   = 1'b1;
        cfg_wr_addr_o = CFG_ADDR_PERIOD;
        cfg_wr_data_o = REF_PERIOD;
      end
      ST_LOCK: begin
        cfg_wr_en_o   = 1'b1;
        cfg_wr_data_o = LOCK_KEY;
      end
      ST_CAL: begin
        cal_req_o   = 1'b1;
        waiting_o   = 1'b1;
        step_hit_o  = cal_done_i;
        fail_code_o = ERR_CAL;
      end
      ST_ISO: begin
        iso_req_o   = 1'b1;
        iso_on_o    = 1'b1;
        waiting_o   = 1'b1;
        step_hit_o  = iso_done_i;
        fail_code_o = ERR_ISO;
      end
      ST_RELOAD: begin
        reload_req_o = 1'b1;
        waiting_o    = 1'b1;
        step_hit_o   = reload_done_i;
        fail_code_o  = ERR_RELOAD;
      end
      ST_MUX: begin
        mux_req_o   = 1'b1;
        waiting_o   = 1'b1;
        step_hit_o  = mux_ack_i;
        fail_code_o = ERR_DEISO;
      end
      ST_DEISO: begin
        iso_req_o   = 1'b1;
        waiting_o   = 1'b1;
        step_hit_o  = iso_done_i;
        fail_code_o = ERR_DEISO;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/iorecal_status.sv
module iorecal_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept_i,
  input  logic       fail_i,
  input  logic [3:0] fail_code_i,
  input  logic       publish_i,
  output logic [3:0] err_code_o
);
  logic [3:0] pend_q;
  logic [3:0] pub_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      pub_q  <= '0;
    end else if (accept_i) begin
      pend_q <= '0;
      pub_q  <= '0;
    end else begin
      if (fail_i)    pend_q <= fail_code_i;
      if (publish_i) pub_q  <= pend_q;
    end
  end

  assign err_code_o = pub_q;
endmodule

// File: rtl/iorecal_seq.sv
module iorecal_seq
  import iorecal_pkg::*;
#(
  parameter int               TIMEOUT_CYC = 64,
  parameter int               KEY_W       = 16,
  parameter logic [KEY_W-1:0] UNLOCK_KEY  = 16'hAAAA,
  parameter logic [KEY_W-1:0] LOCK_KEY    = 16'hAAAB,
  parameter logic [KEY_W-1:0] REF_PERIOD  = 16'h02EF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [3:0]       err_code_o,
  output logic             cfg_wr_en_o,
  output logic [1:0]       cfg_wr_addr_o,
  output logic [KEY_W-1:0] cfg_wr_data_o,
  output logic             cal_req_o,
  input  logic             cal_done_i,
  output logic             iso_req_o,
  output logic             iso_on_o,
  input  logic             iso_done_i,
  output logic             reload_req_o,
  input  logic             reload_done_i,
  output logic             mux_req_o,
  input  logic             mux_ack_i
);
  rc_state_e  st_q, st_d;
  logic       waiting, step_hit, expired, accept;
  logic [3:0] fail_code;

  iorecal_step_port #(
    .KEY_W(KEY_W), .UNLOCK_KEY(UNLOCK_KEY),
    .LOCK_KEY(LOCK_KEY), .REF_PERIOD(REF_PERIOD)
  ) u_port (
    .st_i(st_q),
    .cal_done_i(cal_done_i), .iso_done_i(iso_done_i),
    .reload_done_i(reload_done_i), .mux_ack_i(mux_ack_i),
    .cal_req_o(cal_req_o), .iso_req_o(iso_req_o), .iso_on_o(iso_on_o),
    .reload_req_o(reload_req_o), .mux_req_o(mux_req_o),
    .cfg_wr_en_o(cfg_wr_en_o), .cfg_wr_addr_o(cfg_wr_addr_o),
    .cfg_wr_data_o(cfg_wr_data_o),
    .waiting_o(waiting), .step_hit_o(step_hit), .fail_code_o(fail_code)
  );

  iorecal_wait_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(st_d != st_q),
    .active_i(waiting), .hit_i(step_hit), .expired_o(expired)
  );

  iorecal_status u_status (
    .clk(clk), .rst_n(rst_n), .accept_i(accept),
    .fail_i(expired), .fail_code_i(fail_code),
    .publish_i(st_q == ST_LOCK), .err_code_o(err_code_o)
  );

  assign busy_o = (st_q != ST_IDLE) && (st_q != ST_FIN);
  assign done_o = (st_q == ST_FIN);
  assign accept = start_i && !busy_o;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE, ST_FIN:     st_d = accept ? ST_UNLOCK : ST_IDLE;
      ST_UNLOCK, ST_PERIOD,
      ST_LOCK:             st_d = step_after(st_q);
      default: begin
        if (step_hit)     st_d = step_after(st_q);
        else if (expired) st_d = ST_LOCK;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/iorecal_seq_chk.sv
module iorecal_seq_chk #(
  parameter int               KEY_W      = 16,
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hAAAA,
  parameter logic [KEY_W-1:0] LOCK_KEY   = 16'hAAAB
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [3:0]       err_code_o,
  input logic             cfg_wr_en_o,
  input logic [1:0]       cfg_wr_addr_o,
  input logic [KEY_W-1:0] cfg_wr_data_o,
  input logic             cal_req_o,
  input logic             iso_req_o,
  input logic             iso_on_o,
  input logic             iso_done_i,
  input logic             reload_req_o,
  input logic             mux_req_o
);
  logic pads_held;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       pads_held <= 1'b0;
    else if (iso_req_o && iso_done_i) pads_held <= iso_on_o;
  end

  assert_open_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en_o && cfg_wr_addr_o == 2'd0 && cfg_wr_data_o == UNLOCK_KEY)
      |-> $past(start_i && !busy_o));

  assert_one_action_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_wr_en_o, cal_req_o, iso_req_o, reload_req_o, mux_req_o}));

  assert_closed_before_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(cfg_wr_en_o && cfg_wr_addr_o == 2'd0 && cfg_wr_data_o == LOCK_KEY));

  assert_code_hidden_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (err_code_o == 4'h0));

  assert_code_single_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(err_code_o) <= 1);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_mux_isolated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mux_req_o |-> pads_held);
endmodule

bind iorecal_seq iorecal_seq_chk #(
  .KEY_W(KEY_W), .UNLOCK_KEY(UNLOCK_KEY), .LOCK_KEY(LOCK_KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .err_code_o(err_code_o), .cfg_wr_en_o(cfg_wr_en_o),
  .cfg_wr_addr_o(cfg_wr_addr_o), .cfg_wr_data_o(cfg_wr_data_o),
  .cal_req_o(cal_req_o), .iso_req_o(iso_req_o), .iso_on_o(iso_on_o),
  .iso_done_i(iso_done_i), .reload_req_o(reload_req_o), .mux_req_o(mux_req_o)
);

// File: tb/tb_iorecal_seq.sv
module tb_iorecal_seq;
  localparam int T     = 16;
  localparam int NEVER = 1000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, cfg_en, cal_req, cal_done, iso_req, iso_on, iso_done;
  logic reload_req, reload_done, mux_req, mux_ack;
  logic [3:0]  err;
  logic [1:0]  cfg_addr;
  logic [15:0] cfg_data;

  always #10 clk = ~clk;

  iorecal_seq #(.TIMEOUT_CYC(T)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .err_code_o(err), .cfg_wr_en_o(cfg_en), .cfg_wr_addr_o(cfg_addr),
    .cfg_wr_data_o(cfg_data), .cal_req_o(cal_req), .cal_done_i(cal_done),
    .iso_req_o(iso_req), .iso_on_o(iso_on), .iso_done_i(iso_done),
    .reload_req_o(reload_req), .reload_done_i(reload_done),
    .mux_req_o(mux_req), .mux_ack_i(mux_ack)
  );

  // responder stubs: answer after a programmable number of request cycles
  int dc = 0, di = 0, dr = 0, dm = 0, dd = 0;
  int cc = 0, ic = 0, rc = 0, mc = 0;
  always @(posedge clk) begin
    cc <= cal_req    ? cc + 1 : 0;
    ic <= iso_req    ? ic + 1 : 0;
    rc <= reload_req ? rc + 1 : 0;
    mc <= mux_req    ? mc + 1 : 0;
  end
  assign cal_done    = cal_req && (cc == dc);
  assign iso_done    = iso_req && (ic == (iso_on ? di : dd));
  assign reload_done = reload_req && (rc == dr);
  assign mux_ack     = mux_req && (mc == dm);

  // event log sampled at the falling edge
  // codes: 1 open,2 period,3 cal,4 isolate,5 reload,6 mux,7 release,8 close,9 done,15 bad
  int log_q [32];
  int log_n = 0, done_cnt = 0, cal_hi = 0, viol_err = 0, viol_mux = 0;
  logic [3:0] err_at_done = 0;
  logic p_cal = 0, p_iso = 0, p_rel = 0, p_mux = 0, isolated = 0;
  task automatic add_ev(input int c);
    if (log_n < 32) log_q[log_n] = c;
    log_n++;
  endtask
  always @(negedge clk) if (rst_n) begin
    if (cfg_en) begin
      if (cfg_addr == 2'd0 && cfg_data == 16'hAAAA)      add_ev(1);
      else if (cfg_addr == 2'd1 && cfg_data == 16'h02EF) add_ev(2);
      else if (cfg_addr == 2'd0 && cfg_data == 16'hAAAB) add_ev(8);
      else                                               add_ev(15);
    end
    if (cal_req && !p_cal) add_ev(3);
    if (iso_req && !p_iso && !p_rel) add_ev(iso_on ? 4 : 7);
    if (reload_req && !p_reload_q) add_ev(5);
    if (mux_req && !p_mux) add_ev(6);
    if (done) begin add_ev(9); done_cnt++; err_at_done = err; end
    if (cal_req) cal_hi++;
    if (busy && err != 4'h0) viol_err++;
    if (mux_req && !isolated) viol_mux++;
    if (iso_req && iso_done) isolated = iso_on;
    p_cal = cal_req; p_mux = mux_req;
    p_iso = iso_req && iso_on; p_rel = iso_req && !iso_on;
    p_reload_q = reload_req;
  end
  logic p_reload_q = 0;

  int total = 0, bad = 0;
  task automatic check(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic run_seq(input int c, input int i, input int r, input int m,
                         input int d, input logic [39:0] exp, input int exp_n,
                         input int exp_err, input int exp_cal_hi, input bit poke,
                         input string rq);
    dc = c; di = i; dr = r; dm = m; dd = d;
    log_n = 0; done_cnt = 0; cal_hi = 0; viol_err = 0; viol_mux = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1;                       // R1: must be ignored while busy
      @(negedge clk) start = 1'b0;
    end
    for (int w = 0; w < 2000 && done_cnt == 0; w++) @(negedge clk);
    repeat (3) @(negedge clk);
    check({rq, " event count"}, log_n, exp_n);
    for (int k = 0; k < exp_n && k < log_n; k++)
      check({rq, " event order"}, log_q[k], int'(exp[4*(exp_n-1-k) +: 4]));
    check("R7 code at done", int'(err_at_done), exp_err);
    check("R8 code held", int'(err), exp_err);
    check("R8 hidden while busy", viol_err, 0);
    check("R9 single done", done_cnt, 1);
    check("R9 idle after", int'(busy), 0);
    check("R10 mux only isolated", viol_mux, 0);
    if (exp_cal_hi >= 0) check("R4 R5 cal request length", cal_hi, exp_cal_hi);
  endtask

  task automatic t_reset();
    check("R9 reset busy", int'(busy), 0);
    check("R9 reset done", int'(done), 0);
    check("R8 reset code", int'(err), 0);
    check("R3 reset idle outputs",
          int'({cfg_en, cal_req, iso_req, reload_req, mux_req}), 0);
  endtask

  task automatic t_fast();      // R2 R3 R11
    run_seq(0, 0, 0, 0, 0, 40'h123456789, 9, 0, 1, 1'b0, "R2 fast");
  endtask
  task automatic t_last_cycle(); // R5 boundary success, R4 held request
    run_seq(T-1, T-1, T-1, T-1, T-1, 40'h123456789, 9, 0, T, 1'b0, "R5 last cycle");
  endtask
  task automatic t_cal_late();   // R5 one cycle too late
    run_seq(T, 0, 0, 0, 0, 40'h12389, 5, 1, T, 1'b0, "R6 cal late");
  endtask
  task automatic t_iso_fail();
    run_seq(0, NEVER, 0, 0, 0, 40'h123489, 6, 4, -1, 1'b0, "R6 isolate");
  endtask
  task automatic t_reload_fail();
    run_seq(0, 0, NEVER, 0, 0, 40'h1234589, 7, 8, -1, 1'b0, "R6 reload");
  endtask
  task automatic t_mux_fail();
    run_seq(0, 0, 0, NEVER, 0, 40'h12345689, 8, 2, -1, 1'b0, "R6 mux");
  endtask
  task automatic t_deiso_fail();
    run_seq(0, 0, 0, 0, NEVER, 40'h123456789, 9, 2, -1, 1'b0, "R6 release");
  endtask
  task automatic t_busy_start(); // R1
    run_seq(8, 2, 2, 2, 2, 40'h123456789, 9, 0, 9, 1'b1, "R1 busy start");
  endtask
  task automatic t_hold_then_clear(); // R8
    run_seq(0, NEVER, 0, 0, 0, 40'h123489, 6, 4, -1, 1'b0, "R8 fail run");
    repeat (10) @(negedge clk);
    check("R8 code still held", int'(err), 4);
    run_seq(0, 0, 0, 0, 0, 40'h123456789, 9, 0, 1, 1'b0, "R8 clean run");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_fast();
    t_last_cycle();
    t_cal_late();
    t_iso_fail();
    t_reload_fail();
    t_mux_fail();
    t_deiso_fail();
    t_busy_start();
    t_hold_then_clear();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule